// File: doc/BRIEF.md
# Banked RAM Host Access Port

This block gives a 32-bit host register bus access to a local RAM. The RAM is split into two banks. A bank 0 cell holds two 32-bit words and a bank 1 cell holds three. Each bank has four kinds of register: an access-control register, an address register, a mode register, and one transfer latch for each word of its cell. The host fills the latches and then commits them to a cell, or it makes the bank copy a cell into the latches and reads them back. The address can step forward on its own after each cell.

The mode register picks one latch as the trigger. In write mode, writing the trigger latch commits the whole cell. With autoincrement set, touching the trigger latch also moves the address to the next cell. This works the same way for a write, and for a read in read mode. The access-control register changes what a write to the address register does. One value turns that write into a "fetch again from the held address" command and discards the written data. Another value stores the new address and fetches that cell at once. The storage of both banks sits inside the block. Each bank's row and column counts are parameters, and at full size they are 2048 x 1024 cells for bank 0 and 1024 x 512 cells for bank 1.

Top module: `wram_host_port`

## Requirements
- R1: After reset, `busy` is 0 and every transfer latch of both banks reads as zero.
- R2: Register indices: bank 0 uses base 0x40 and bank 1 uses base 0x50. From the base, access control is at +0, address at +1, mode at +2, and latch k at +4+k. A write to a latch stores the word. A read of a latch returns that word in the same cycle as the read strobe, with no wait states.
- R3: Mode fields are trigger select in bits 1:0, write enable in bit 3 and autoincrement in bit 6. In write mode, a write to the trigger latch commits all latches of the bank to the cell at the current address, with latch k as word k. A write to any other latch commits nothing.
- R4: A commit raises `busy` for exactly the one clock after the triggering write. Any host write presented while `busy` is high is dropped and changes no latch or register.
- R5: In write mode with autoincrement set, the address advances by one cell after each commit.
- R6: In read mode (bit 3 = 0), latch writes never commit or raise `busy`. With autoincrement set, a host read of the trigger latch advances the address by one cell.
- R7: While access control holds 0x00820000, a write to the address register keeps the address, discards the written value, and loads the latches from the cell at the held address.
- R8: While access control holds 0x00A20000, a write to the address register stores the new address and loads that cell into the latches in the same clock. With any other value, the write only stores the address.
- R9: The address register holds the column in bits 9:0 and the row in bits 20:10. Stepping past the last column of a bank sets the column to 0 and increments the row.
- R10: Bank 1 has three latches, and the trigger can be set to latch 2. Activity on one bank leaves the other bank's latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_idx | input | 7 | Register index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data (combinational from index) |
| busy | output | 1 | High for the one clock in which a cell commit happens |

## Verification
The bench writes the second latch before the first in explicit-address mode. A design that treats any latch as the trigger would commit early, with a half-filled cell and a spurious `busy`. It pushes a write into the busy clock; a design that does not stall would corrupt the latch it names. It drives autoincrement in both directions across the last column of a row, where a missing row carry sends the third cell back to column 0 of the same row. It also repeats manual-latch fetches after scribbling over the latches, which exposes a design that lets the discarded write data move the address.

// File: rtl/wram_pkg.sv
package wram_pkg;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned IDX_W  = 7;
   localparam int unsigned COL_FW = 10;
   localparam int unsigned ROW_FW = 11;
   localparam int unsigned ADDR_W = ROW_FW + COL_FW;

   localparam logic [DATA_W-1:0] CTRL_MANUAL = 32'h0082_0000;
   localparam logic [DATA_W-1:0] CTRL_IMMED  = 32'h00A2_0000;

   localparam logic [3:0] OFS_CTRL  = 4'd0;
   localparam logic [3:0] OFS_ADDR  = 4'd1;
   localparam logic [3:0] OFS_MODE  = 4'd2;
   localparam logic [3:0] OFS_LATCH = 4'd4;

   localparam int unsigned MODE_WR_BIT  = 3;
   localparam int unsigned MODE_INC_BIT = 6;

   typedef struct packed {
      logic [ROW_FW-1:0] row;
      logic [COL_FW-1:0] col;
   } wram_addr_t;

   typedef struct packed {
      logic       inc;
      logic       wr;
      logic [1:0] trig;
   } wram_mode_t;
endpackage

// File: rtl/wram_addr_step.sv
module wram_addr_step
   import wram_pkg::*;
#(
   parameter int unsigned ROW_W = 3,
   parameter int unsigned COL_W = 3
) (
   input  wram_addr_t cur,
   output wram_addr_t nxt
);
   localparam logic [COL_FW-1:0] COL_LAST = COL_FW'((1 << COL_W) - 1);
   localparam logic [ROW_FW-1:0] ROW_LAST = ROW_FW'((1 << ROW_W) - 1);

   generate
      if (COL_W > COL_FW || ROW_W > ROW_FW) begin : g_bad_geom
         $error("wram_addr_step: bank geometry exceeds address fields");
      end
   endgenerate

   always_comb begin
      nxt = cur;
      if (cur.col >= COL_LAST) begin
         nxt.col = '0;
         nxt.row = (cur.row >= ROW_LAST) ? '0 : cur.row + 1'b1;
      end else begin
         nxt.col = cur.col + 1'b1;
      end
   end
endmodule

// File: rtl/wram_cell_store.sv
module wram_cell_store #(
   parameter int unsigned WORDS = 2,
   parameter int unsigned IX_W  = 6
) (
   input  logic                  clk,
   input  logic                  we,
   input  logic [IX_W-1:0]       waddr,
   input  logic [WORDS*32-1:0]   wdata,
   input  logic [IX_W-1:0]       raddr,
   output logic [WORDS*32-1:0]   rdata
);
   localparam int unsigned DEPTH = 1 << IX_W;

   generate
      if (DEPTH > 4096) begin : g_too_deep
         $error("wram_cell_store: model depth too large");
      end
   endgenerate

   logic [WORDS*32-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/wram_bank_port.sv
module wram_bank_port
   import wram_pkg::*;
#(
   parameter logic [IDX_W-1:0] BASE  = 7'h40,
   parameter int unsigned      WORDS = 2,
   parameter int unsigned      ROW_W = 3,
   parameter int unsigned      COL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_i,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] rdata_o,
   output logic              busy_o
);
   localparam int unsigned IX_W = ROW_W + COL_W;
   localparam int unsigned CW   = WORDS * DATA_W;
   localparam int unsigned LS_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   generate
      if (WORDS < 1 || WORDS > 4) begin : g_bad_words
         $error("wram_bank_port: WORDS must be 1..4");
      end
      if (BASE[3:0] != 4'd0) begin : g_bad_base
         $error("wram_bank_port: BASE must be 16-aligned");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q;
   wram_mode_t        mode_q;
   wram_addr_t        addr_q, addr_nxt, wr_addr;
   logic [DATA_W-1:0] lat_q [WORDS];
   logic              pend_q;

   logic              hit, is_latch, is_trig;
   logic [3:0]        sub, lat_ofs;
   logic [LS_W-1:0]   lat_sel;
   logic [IX_W-1:0]   rd_ix, wr_ix;
   logic [CW-1:0]     rd_cell, wr_cell;

   assign hit      = (host_idx[IDX_W-1:4] == BASE[IDX_W-1:4]);
   assign sub      = host_idx[3:0];
   assign lat_ofs  = sub - OFS_LATCH;
   assign is_latch = hit && (sub >= OFS_LATCH) && (lat_ofs < 4'(WORDS));
   assign lat_sel  = LS_W'(lat_ofs);
   assign is_trig  = (lat_ofs == {2'b00, mode_q.trig});
   assign wr_addr  = wram_addr_t'(host_wdata[ADDR_W-1:0]);

   function automatic logic [IX_W-1:0] cell_ix(input wram_addr_t a);
      return {a.row[ROW_W-1:0], a.col[COL_W-1:0]};
   endfunction

   assign rd_ix = (ctrl_q == CTRL_IMMED) ? cell_ix(wr_addr) : cell_ix(addr_q);
   assign wr_ix = cell_ix(addr_q);

   genvar g;
   generate
      for (g = 0; g < WORDS; g++) begin : g_pack
         assign wr_cell[g*DATA_W +: DATA_W] = lat_q[g];
      end
   endgenerate

   wram_addr_step #(.ROW_W(ROW_W), .COL_W(COL_W)) u_step (
      .cur (addr_q),
      .nxt (addr_nxt)
   );

   wram_cell_store #(.WORDS(WORDS), .IX_W(IX_W)) u_store (
      .clk   (clk),
      .we    (pend_q),
      .waddr (wr_ix),
      .wdata (wr_cell),
      .raddr (rd_ix),
      .rdata (rd_cell)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
         addr_q <= '0;
         pend_q <= 1'b0;
         for (int k = 0; k < WORDS; k++) lat_q[k] <= '0;
      end else if (pend_q) begin
         pend_q <= 1'b0;
         if (mode_q.inc) addr_q <= addr_nxt;
      end else if (!stall_i) begin
         if (host_wr && hit) begin
            if (sub == OFS_CTRL) begin
               ctrl_q <= host_wdata;
            end else if (sub == OFS_MODE) begin
               mode_q.trig <= host_wdata[1:0];
               mode_q.wr   <= host_wdata[MODE_WR_BIT];
               mode_q.inc  <= host_wdata[MODE_INC_BIT];
            end else if (sub == OFS_ADDR) begin
               if (ctrl_q == CTRL_MANUAL) begin
                  for (int k = 0; k < WORDS; k++) lat_q[k] <= rd_cell[k*DATA_W +: DATA_W];
               end else begin
                  addr_q <= wr_addr;
                  if (ctrl_q == CTRL_IMMED) begin
                     for (int k = 0; k < WORDS; k++) lat_q[k] <= rd_cell[k*DATA_W +: DATA_W];
                  end
               end
            end else if (is_latch) begin
               lat_q[lat_sel] <= host_wdata;
               if (mode_q.wr && is_trig) pend_q <= 1'b1;
            end
         end else if (host_rd && is_latch && is_trig && !mode_q.wr && mode_q.inc) begin
            addr_q <= addr_nxt;
         end
      end
   end

   assign rdata_o = is_latch ? lat_q[lat_sel] : '0;
   assign busy_o  = pend_q;

   AST_FLUSH_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> !pend_q); // R4
   AST_STALL_HOLDS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_i && !pend_q) |=> ($stable(ctrl_q) && $stable(addr_q) && $stable(mode_q))); // R4
   AST_MANUAL_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && hit && sub == OFS_ADDR && ctrl_q == CTRL_MANUAL && !stall_i && !pend_q)
      |=> $stable(addr_q)); // R7
   AST_IMMED_ADDR_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && hit && sub == OFS_ADDR && ctrl_q == CTRL_IMMED && !stall_i && !pend_q)
      |=> (addr_q == $past(wr_addr))); // R8
   AST_READMODE_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && is_latch && !mode_q.wr && !pend_q) |=> !pend_q); // R6
   AST_AUTOINC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && mode_q.inc) |=> (addr_q != $past(addr_q))); // R5
endmodule

// File: rtl/wram_host_port.sv
module wram_host_port
   import wram_pkg::*;
#(
   parameter logic [IDX_W-1:0] B0_BASE  = 7'h40,
   parameter logic [IDX_W-1:0] B1_BASE  = 7'h50,
   parameter int unsigned      B0_ROW_W = 3,
   parameter int unsigned      B0_COL_W = 3,
   parameter int unsigned      B1_ROW_W = 2,
   parameter int unsigned      B1_COL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              busy
);
   localparam int unsigned B0_WORDS = 2;
   localparam int unsigned B1_WORDS = 3;

   generate
      if (B0_BASE[IDX_W-1:4] == B1_BASE[IDX_W-1:4]) begin : g_overlap
         $error("wram_host_port: bank bases overlap");
      end
   endgenerate

   logic [DATA_W-1:0] rd0, rd1;
   logic              busy0, busy1;

   wram_bank_port #(.BASE(B0_BASE), .WORDS(B0_WORDS), .ROW_W(B0_ROW_W), .COL_W(B0_COL_W)) u_bank0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .stall_i    (busy),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_idx   (host_idx),
      .host_wdata (host_wdata),
      .rdata_o    (rd0),
      .busy_o     (busy0)
   );

   wram_bank_port #(.BASE(B1_BASE), .WORDS(B1_WORDS), .ROW_W(B1_ROW_W), .COL_W(B1_COL_W)) u_bank1 (
      .clk        (clk),
      .rst_n      (rst_n),
      .stall_i    (busy),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_idx   (host_idx),
      .host_wdata (host_wdata),
      .rdata_o    (rd1),
      .busy_o     (busy1)
   );

   assign host_rdata = rd0 | rd1;
   assign busy       = busy0 | busy1;

   AST_ONE_BANK_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy0 && busy1)); // R4
endmodule

// File: tb/tb_wram_host_port.sv
module tb_wram_host_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [6:0]  host_idx = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        busy;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [6:0] B0_CTRL = 7'h40, B0_ADDR = 7'h41, B0_MODE = 7'h42, B0_L0 = 7'h44, B0_L1 = 7'h45;
   localparam logic [6:0] B1_CTRL = 7'h50, B1_ADDR = 7'h51, B1_MODE = 7'h52, B1_L0 = 7'h54;
   localparam logic [31:0] MANUAL = 32'h0082_0000, IMMED = 32'h00A2_0000;
   localparam logic [31:0] A0 = 32'hA000_0000, B0 = 32'hB000_0000;

   always #10 clk = ~clk;

   wram_host_port dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] idx, input logic [31:0] d);
      @(negedge clk);
      while (busy) @(negedge clk);
      host_idx = idx; host_wdata = d; host_wr = 1'b1;
      @(posedge clk); #1 host_wr = 1'b0;
   endtask

   task automatic rd(input logic [6:0] idx, output logic [31:0] v);
      @(negedge clk);
      while (busy) @(negedge clk);
      host_idx = idx; host_rd = 1'b1;
      #1 v = host_rdata;
      @(posedge clk); #1 host_rd = 1'b0;
   endtask

   task automatic peek0(input logic [31:0] a, input logic [31:0] e0, input logic [31:0] e1, input string tag);
      logic [31:0] v;
      wr(B0_MODE, 32'h0); wr(B0_CTRL, IMMED); wr(B0_ADDR, a);
      rd(B0_L0, v); chk({tag, " word0"}, v, e0);
      rd(B0_L1, v); chk({tag, " word1"}, v, e1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 busy after reset", {31'b0, busy}, 32'h0);
      rd(B0_L0, v); chk("R1 bank0 latch0", v, 32'h0);
      rd(B1_L0 + 7'd2, v); chk("R1 bank1 latch2", v, 32'h0);
   endtask

   task automatic t_latch_rw();
      logic [31:0] v;
      wr(B0_MODE, 32'h0);
      wr(B0_L0, 32'h1234_5678); wr(B0_L1, 32'h9ABC_DEF0);
      chk("R6 read-mode latch write no busy", {31'b0, busy}, 32'h0);
      rd(B0_L0, v); chk("R2 latch0 readback", v, 32'h1234_5678);
      rd(B0_L1, v); chk("R2 latch1 readback", v, 32'h9ABC_DEF0);
   endtask

   task automatic t_explicit_write();
      logic [31:0] v;
      wr(B0_CTRL, 32'h0); wr(B0_ADDR, 32'h0000_0402); wr(B0_MODE, 32'h08);
      wr(B0_L1, 32'h1111_1111);
      chk("R3 non-trigger write no commit", {31'b0, busy}, 32'h0);
      wr(B0_L0, 32'h2222_2222);
      chk("R4 busy after trigger", {31'b0, busy}, 32'h1);
      @(negedge clk);
      host_idx = B0_L1; host_wdata = 32'hBAD0_BAD0; host_wr = 1'b1;
      @(posedge clk); #1 host_wr = 1'b0;
      chk("R4 busy lasts one clock", {31'b0, busy}, 32'h0);
      rd(B0_L1, v); chk("R4 write during busy dropped", v, 32'h1111_1111);
      peek0(32'h0000_0402, 32'h2222_2222, 32'h1111_1111, "R3 R8 committed cell");
   endtask

   task automatic t_write_autoinc();
      wr(B0_CTRL, 32'h0); wr(B0_ADDR, 32'h0000_0806); wr(B0_MODE, 32'h49);
      for (int k = 0; k < 3; k++) begin
         wr(B0_L0, A0 + k); wr(B0_L1, B0 + k);
      end
      peek0(32'h0000_0806, A0, B0, "R5 cell col6");
      peek0(32'h0000_0807, A0 + 1, B0 + 1, "R5 cell col7");
      peek0(32'h0000_0C00, A0 + 2, B0 + 2, "R9 write carry row3 col0");
   endtask

   task automatic t_manual();
      logic [31:0] v;
      wr(B0_MODE, 32'h0); wr(B0_CTRL, 32'h0); wr(B0_ADDR, 32'h0000_0806);
      wr(B0_L0, 32'hDEAD_0000); wr(B0_L1, 32'hDEAD_0001);
      wr(B0_CTRL, MANUAL); wr(B0_ADDR, 32'h0000_0007);
      rd(B0_L0, v); chk("R7 manual fetch word0", v, A0);
      rd(B0_L1, v); chk("R7 manual fetch word1", v, B0);
      wr(B0_L0, 32'hDEAD_0002);
      wr(B0_ADDR, 32'h0000_0C00);
      rd(B0_L0, v); chk("R7 address kept after manual write", v, A0);
   endtask

   task automatic t_read_autoinc();
      logic [31:0] v;
      wr(B0_CTRL, 32'h0); wr(B0_ADDR, 32'h0000_0806);
      wr(B0_CTRL, MANUAL); wr(B0_MODE, 32'h41);
      for (int k = 0; k < 3; k++) begin
         wr(B0_ADDR, 32'h0);
         rd(B0_L0, v); chk($sformatf("R6 R9 read-inc word0 step%0d", k), v, A0 + k);
         rd(B0_L1, v); chk($sformatf("R6 R9 read-inc word1 step%0d", k), v, B0 + k);
      end
   endtask

   task automatic t_bank1();
      logic [31:0] v;
      wr(B1_CTRL, 32'h0); wr(B1_ADDR, 32'h0000_0401); wr(B1_MODE, 32'h0A);
      wr(B1_L0, 32'hC000_0000); wr(B1_L0 + 7'd1, 32'hC000_0001);
      chk("R10 two of three latches no commit", {31'b0, busy}, 32'h0);
      wr(B1_L0 + 7'd2, 32'hC000_0002);
      chk("R10 latch2 trigger commits", {31'b0, busy}, 32'h1);
      wr(B1_MODE, 32'h0); wr(B1_L0, 32'h0); wr(B1_L0 + 7'd1, 32'h0); wr(B1_L0 + 7'd2, 32'h0);
      wr(B1_CTRL, IMMED); wr(B1_ADDR, 32'h0000_0401);
      for (int k = 0; k < 3; k++) begin
         rd(B1_L0 + 7'(k), v); chk($sformatf("R10 bank1 word%0d", k), v, 32'hC000_0000 + k);
      end
      rd(B0_L0, v); chk("R10 bank0 latches untouched", v, A0 + 2);
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_latch_rw();
      t_explicit_write();
      t_write_autoinc();
      t_manual();
      t_read_autoinc();
      t_bank1();
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end
endmodule